// File: doc/BRIEF.md
# Electronic Shutter Storage Controller

This block decides when pixel storage begins for each frame of an image sensor's timing chain. It receives the current line index and a one-cycle frame-start pulse from the timing generator, together with an exposure code and a multi-frame storage code from the command decoder. From these it produces a storage-start pulse. The pulse lasts one full line and is placed so that the time left until the next readout equals the programmed exposure. When the exposure code is zero, the shutter is off: the pulse falls on line 0 and storage covers the whole frame.

For long exposures, storage can stretch over 2 to 16 frames. The pulse is then issued only in the last frame before readout. A frame-valid output stays low for every intermediate frame, so downstream logic drops that image data. Settings are shadowed and take effect only at a frame start, so a command that arrives mid-frame never splits an exposure.

When the sensor is synchronised from outside, the block becomes a bypass. The external shutter pulse is forwarded to the output with one register of delay, and the frame-valid output is held high. In that case, long storage is set by the external vertical timing.

Top module: `shutter_storage_ctrl`

## Requirements
- R1: After reset, in internal mode, `str_o` and `frame_valid_o` stay low until the first `frame_start_i` pulse, whatever `line_idx_i` holds.
- R2: For an exposure code c in 1..523, the exposure is c+1 lines. `str_o` is high for exactly one line, on line index 524−c, and follows `line_idx_i` with one clock of latency.
- R3: An exposure code of 0 means the shutter is off: the storage-start pulse falls on line 0, so the exposure is the full 525 lines.
- R4: Exposure codes of 524 and above are clamped to 524 lines, which puts the pulse on line 1.
- R5: In internal mode, at most one storage-start pulse rises between two frame-start pulses.
- R6: The exposure and storage codes are sampled on the `frame_start_i` cycle. A change made during a frame does not move that frame's pulse and applies from the next frame start.
- R7: A storage code k in 1..15 gives storage over k+1 frames. The pulse fires only in the last frame of each cycle, and `frame_valid_o` is low for the k intermediate frames and high in the readout frame. A code of 0 makes every frame both a firing frame and a valid frame.
- R8: In internal mode, `frame_valid_o` changes only in the cycle after a `frame_start_i` pulse.
- R9: With `ext_mode_i` high, `str_o` equals `ext_str_i` delayed by one clock and `frame_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start_i | input | 1 | One-cycle pulse in the first cycle of line 0 |
| line_idx_i | input | 10 | Current line index, 0..524 |
| exp_code_i | input | 10 | Exposure code: 0 = shutter off, c = c+1 lines |
| frames_code_i | input | 4 | Storage code: k = k+1 frames of storage |
| ext_mode_i | input | 1 | 1 = external synchronisation (bypass) |
| ext_str_i | input | 1 | External shutter pulse, forwarded in bypass |
| str_o | output | 1 | Storage-start pulse |
| frame_valid_o | output | 1 | High when the frame being read out holds a finished exposure |

## Verification
The pulse position is checked with a range of exposure codes. Codes 1 and 523 test the two ends of the linear formula, code 0 tests the shutter-off case, and codes 524 and 1000 test the clamp. A frame whose exposure code is rewritten partway through shows whether the shadow registers hold the old target. Storage cycles of 2 and 16 frames, entered from a steady single-frame state, separate three things: a correct phase wrap, an off-by-one count of intermediate frames, and a pulse placed in the wrong frame. An irregular external pulse train in bypass mode shows whether the forwarding delay is exactly one clock.

// File: rtl/shutter_pkg.sv
// Shared definitions for the shutter storage controller.
// Assumes exposure code c selects c+1 lines, with 0 meaning a full frame.
package shutter_pkg;

    // Source of the storage-start output.
    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } str_src_e;

    // Line index on which storage must begin so that `lines` minus index equals the exposure.
    function automatic int unsigned str_target(input int unsigned code,
                                               input int unsigned lines);
        int unsigned expo;
        if (code == 0)
            expo = lines;
        else if (code >= lines - 1)
            expo = lines - 1;
        else
            expo = code + 1;
        return lines - expo;
    endfunction

endpackage

// File: rtl/shutter_cfg_shadow.sv
// Holds the exposure and storage codes that apply to the current frame.
// Assumes frame_start_i is a single-cycle pulse. In that cycle the live
// inputs are passed through so the first line already sees new settings.
module shutter_cfg_shadow #(
    parameter int EXP_W = 10,
    parameter int FRM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic [EXP_W-1:0] exp_code_i,
    input  logic [FRM_W-1:0] frames_code_i,
    output logic [EXP_W-1:0] exp_code_eff_o,
    output logic [FRM_W-1:0] frames_code_eff_o
);

    logic [EXP_W-1:0] exp_q;
    logic [FRM_W-1:0] frm_q;

    // Capture the codes once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
            frm_q <= '0;
        end else if (frame_start_i) begin
            exp_q <= exp_code_i;
            frm_q <= frames_code_i;
        end
    end

    // Effective codes: the live value on the frame-start cycle, else the shadow.
    always_comb begin
        exp_code_eff_o    = frame_start_i ? exp_code_i    : exp_q;
        frames_code_eff_o = frame_start_i ? frames_code_i : frm_q;
    end

endmodule

// File: rtl/storage_sequencer.sv
// Tracks the position inside a multi-frame storage cycle.
// Phase 0 is the readout frame; the phase equal to the storage code is the
// frame in which storage starts. Nothing fires before the first frame start.
module storage_sequencer #(
    parameter int FRM_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic [FRM_W-1:0] frames_code_eff_i,
    output logic             fire_frame_o,
    output logic             frame_ok_o
);

    logic [FRM_W-1:0] phase_q;
    logic [FRM_W-1:0] phase_next;
    logic [FRM_W-1:0] phase_cur;
    logic [FRM_W:0]   phase_inc;
    logic             armed_q;
    logic             ok_q;

    // Next phase, wrapping once the storage length is reached.
    always_comb begin
        phase_inc = {1'b0, phase_q} + 1'b1;
        if (phase_inc > {1'b0, frames_code_eff_i})
            phase_next = '0;
        else
            phase_next = phase_inc[FRM_W-1:0];
        phase_cur    = frame_start_i ? phase_next : phase_q;
        fire_frame_o = (armed_q || frame_start_i) && (phase_cur == frames_code_eff_i);
    end

    // Advance phase and validity at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            armed_q <= 1'b0;
            ok_q    <= 1'b0;
        end else if (frame_start_i) begin
            phase_q <= phase_next;
            armed_q <= 1'b1;
            ok_q    <= (phase_next == '0);
        end
    end

    assign frame_ok_o = ok_q;

endmodule

// File: rtl/str_pulse_gen.sv
// Produces the registered storage-start pulse.
// Internal source: high for the whole line whose index equals the target,
// in a firing frame only. External source: the input pulse, re-timed.
module str_pulse_gen #(
    parameter int LINES = 525,
    parameter int LW    = 10,
    parameter int EXP_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LW-1:0]        line_idx_i,
    input  logic [EXP_W-1:0]     exp_code_eff_i,
    input  logic                 fire_frame_i,
    input  shutter_pkg::str_src_e src_i,
    input  logic                 ext_str_i,
    output logic                 str_o
);

    logic [LW-1:0] target;
    logic          hit;

    // Target line for the effective exposure code, and the match against it.
    always_comb begin
        target = LW'(shutter_pkg::str_target(32'(exp_code_eff_i), LINES));
        hit    = fire_frame_i && (line_idx_i == target);
    end

    // Select the pulse source and register it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            str_o <= 1'b0;
        else if (src_i == shutter_pkg::SRC_EXTERNAL)
            str_o <= ext_str_i;
        else
            str_o <= hit;
    end

endmodule

// File: rtl/shutter_storage_ctrl.sv
// Electronic shutter storage controller.
// Places one storage-start pulse per storage cycle, a programmed number of
// lines before readout, and flags frames that hold no finished exposure.
// Assumes line_idx_i counts 0..LINES-1 and frame_start_i marks line 0.
module shutter_storage_ctrl #(
    parameter int LINES = 525,
    parameter int EXP_W = 10,
    parameter int FRM_W = 4,
    localparam int LW   = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic [LW-1:0]    line_idx_i,
    input  logic [EXP_W-1:0] exp_code_i,
    input  logic [FRM_W-1:0] frames_code_i,
    input  logic             ext_mode_i,
    input  logic             ext_str_i,
    output logic             str_o,
    output logic             frame_valid_o
);

    logic [EXP_W-1:0]      exp_eff;
    logic [FRM_W-1:0]      frm_eff;
    logic                  fire_frame;
    logic                  frame_ok;
    shutter_pkg::str_src_e src;

    // Map the mode pin onto the source select.
    always_comb begin
        src = ext_mode_i ? shutter_pkg::SRC_EXTERNAL : shutter_pkg::SRC_INTERNAL;
    end

    shutter_cfg_shadow #(
        .EXP_W(EXP_W),
        .FRM_W(FRM_W)
    ) u_shadow (
        .clk              (clk),
        .rst_n            (rst_n),
        .frame_start_i    (frame_start_i),
        .exp_code_i       (exp_code_i),
        .frames_code_i    (frames_code_i),
        .exp_code_eff_o   (exp_eff),
        .frames_code_eff_o(frm_eff)
    );

    storage_sequencer #(
        .FRM_W(FRM_W)
    ) u_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .frame_start_i    (frame_start_i),
        .frames_code_eff_i(frm_eff),
        .fire_frame_o     (fire_frame),
        .frame_ok_o       (frame_ok)
    );

    str_pulse_gen #(
        .LINES(LINES),
        .LW   (LW),
        .EXP_W(EXP_W)
    ) u_pulse (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_idx_i    (line_idx_i),
        .exp_code_eff_i(exp_eff),
        .fire_frame_i  (fire_frame),
        .src_i         (src),
        .ext_str_i     (ext_str_i),
        .str_o         (str_o)
    );

    // In bypass the outside timing owns validity, so the flag is forced high.
    assign frame_valid_o = ext_mode_i | frame_ok;

endmodule

// File: rtl/shutter_storage_chk.sv
// Temporal checks on the shutter storage controller's ports.
module shutter_storage_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_start_i,
    input logic ext_mode_i,
    input logic ext_str_i,
    input logic str_o,
    input logic frame_valid_o
);

    logic str_d;
    logic rose_in_frame;
    logic ext_in_frame;

    // Remember past pulse edges and bypass use within the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            str_d         <= 1'b0;
            rose_in_frame <= 1'b0;
            ext_in_frame  <= 1'b0;
        end else begin
            str_d <= str_o;
            if (frame_start_i) begin
                rose_in_frame <= 1'b0;
                ext_in_frame  <= ext_mode_i;
            end else begin
                if (str_o && !str_d) rose_in_frame <= 1'b1;
                if (ext_mode_i)      ext_in_frame  <= 1'b1;
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !str_o);

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode_i && !ext_in_frame && str_o && !str_d) |-> !rose_in_frame);

    // R8
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode_i && $past(!ext_mode_i) && $past(rst_n) && !$past(frame_start_i))
            |-> $stable(frame_valid_o));

    // R9
    bypass_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ext_mode_i) && $past(rst_n)) |-> (str_o == $past(ext_str_i)));

    // R9
    bypass_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode_i |-> frame_valid_o);

endmodule

bind shutter_storage_ctrl shutter_storage_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start_i(frame_start_i),
    .ext_mode_i   (ext_mode_i),
    .ext_str_i    (ext_str_i),
    .str_o        (str_o),
    .frame_valid_o(frame_valid_o)
);

// File: tb/shutter_storage_ctrl_tb.sv
`timescale 1ns/1ps
module shutter_storage_ctrl_tb;

    localparam int LINES     = 525;
    localparam int LINE_CLKS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start_i = 1'b0;
    logic [9:0] line_idx_i = '0;
    logic [9:0] exp_code_i = '0;
    logic [3:0] frames_code_i = '0;
    logic       ext_mode_i = 1'b0;
    logic       ext_str_i = 1'b0;
    logic       str_o;
    logic       frame_valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    shutter_storage_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start_i(frame_start_i),
        .line_idx_i   (line_idx_i),
        .exp_code_i   (exp_code_i),
        .frames_code_i(frames_code_i),
        .ext_mode_i   (ext_mode_i),
        .ext_str_i    (ext_str_i),
        .str_o        (str_o),
        .frame_valid_o(frame_valid_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected pulse line from the exposure rule (R2, R3, R4).
    function automatic int want_line(input int code);
        if (code == 0) return 0;
        if (code >= 524) return 1;
        return 524 - code;
    endfunction

    // Drive one frame and check pulse placement, width and validity.
    // exp_line < 0 means no pulse is expected. chg_line >= 0 rewrites the exposure code mid-frame.
    task automatic run_frame(input int code, input int fr, input int exp_line,
                             input bit exp_fv, input bit prev_fv, input string req,
                             input int chg_line, input int chg_code);
        int hi = 0;
        int rises = 0;
        int rise_line = -1;
        int prev_line = LINES - 1;
        bit last = 0;
        for (int l = 0; l < LINES; l++) begin
            for (int c = 0; c < LINE_CLKS; c++) begin
                @(posedge clk); #1;
                line_idx_i    = 10'(l);
                frame_start_i = (l == 0 && c == 0);
                if (l == 0 && c == 0) begin
                    exp_code_i    = 10'(code);
                    frames_code_i = 4'(fr);
                end
                if (l == chg_line && c == 0) exp_code_i = 10'(chg_code);
                @(negedge clk);
                if (l == 0 && c == 0)
                    check(frame_valid_o == prev_fv, "R8", "valid before frame start",
                          int'(frame_valid_o), int'(prev_fv));
                if (str_o) begin
                    hi++;
                    if (!last) begin
                        rises++;
                        rise_line = prev_line;
                    end
                end
                last = str_o;
                prev_line = l;
            end
        end
        frame_start_i = 1'b0;
        if (exp_line < 0) begin
            check(hi == 0, req, "no pulse expected, high cycles", hi, 0);
        end else begin
            check(rise_line == exp_line, req, "pulse line", rise_line, exp_line);
            check(hi == LINE_CLKS, req, "pulse width cycles", hi, LINE_CLKS);
            check(rises == 1, "R5", "pulses in frame", rises, 1);
        end
        check(frame_valid_o == exp_fv, req, "frame valid", int'(frame_valid_o), int'(exp_fv));
    endtask

    // R1: quiet outputs through reset and until the first frame start.
    task automatic test_reset();
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(str_o == 1'b0, "R1", "str after reset", int'(str_o), 0);
            check(frame_valid_o == 1'b0, "R1", "valid after reset", int'(frame_valid_o), 0);
        end
    endtask

    // R2, R3, R4, R6: single-frame exposure settings.
    task automatic test_exposure();
        run_frame(0,    0, want_line(0),    1, 0, "R3", -1, 0);
        run_frame(1,    0, want_line(1),    1, 1, "R2", -1, 0);
        run_frame(523,  0, want_line(523),  1, 1, "R2", -1, 0);
        run_frame(100,  0, want_line(100),  1, 1, "R6", 200, 400);
        run_frame(400,  0, want_line(400),  1, 1, "R6", -1, 0);
        run_frame(524,  0, want_line(524),  1, 1, "R4", -1, 0);
        run_frame(1000, 0, want_line(1000), 1, 1, "R4", -1, 0);
    endtask

    // R7: storage over k+1 frames.
    task automatic test_long(input int k);
        for (int f = 1; f <= k; f++)
            run_frame(50, k, (f == k) ? want_line(50) : -1, 0, (f == 1), "R7", -1, 0);
        run_frame(50, k, -1, 1, 0, "R7", -1, 0);
    endtask

    // R9: bypass of an external pulse train.
    task automatic test_bypass();
        bit prev = 0;
        for (int i = 0; i < 24; i++) begin
            @(posedge clk); #1;
            ext_mode_i = 1'b1;
            ext_str_i  = (i % 3 == 0) || (i % 7 == 2);
            @(negedge clk);
            if (i > 0) begin
                check(str_o == prev, "R9", "bypass pulse", int'(str_o), int'(prev));
                check(frame_valid_o == 1'b1, "R9", "bypass valid", int'(frame_valid_o), 1);
            end
            prev = ext_str_i;
        end
        @(posedge clk); #1;
        ext_mode_i = 1'b0;
        ext_str_i  = 1'b0;
    endtask

    initial begin
        test_reset();
        test_exposure();
        test_long(1);
        test_long(15);
        run_frame(50, 0, want_line(50), 1, 1, "R7", -1, 0);
        test_bypass();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule